// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces the byte address into an external sample buffer for each access that a transfer engine makes. At the start of a transfer it captures a buffer-select code, a starting offset, a buffer base and a buffer size given as length minus one. From then on, each step strobe describes one access of a given number of bytes. The strobe comes with a byte increment from the format converter.

One cycle after each step, the block presents the following for that access:
- the byte address;
- the number of bytes that fit before the buffer end;
- when a circular wrap falls inside the access, a split flag and the address where the remainder continues.

It also keeps the running offset on a port at all times. The transfer engine can write that offset back into its descriptor when the transfer ends, and in circular mode it is already folded into the buffer range.

Only one buffer code selects circular addressing. Every other code, the linear scratch buffer and the FIFO targets included, addresses the buffer linearly, and base and size have no effect.

Top module: `cbg_addr_gen`

## Requirements
- R1: After reset, acc_valid, acc_split, acc_addr, end_offset and circ_mode are all 0.
- R2: At start, buffer code 4'hE selects circular mode (circ_mode=1). Every other code selects linear mode (circ_mode=0), including 4'hF and the FIFO codes 4'h0 to 4'h3.
- R3: A start strobe loads start_offset, so end_offset equals it on the next cycle, and the first access of the transfer is made at that offset. The offset must not exceed buf_size_m1 in circular mode.
- R4: In circular mode, acc_addr is the latched base plus the current offset, taken modulo 2^OFS_W.
- R5: In linear mode, acc_addr is the current offset and the offset then grows by incr modulo 2^OFS_W. buf_base and buf_size_m1 have no effect on any output.
- R6: In circular mode, an access that ends exactly at the last byte (offset + incr = size_m1 + 1) is not split, and it leaves the offset at 0.
- R7: In circular mode, an access with incr larger than the bytes remaining (size_m1 + 1 - offset) sets acc_split=1 and gives acc_len1 = bytes remaining and acc_addr2 = base. It leaves the offset at incr minus the bytes remaining. Otherwise acc_split=0, acc_len1=incr and acc_addr2=0. The increment must not exceed size_m1 + 1.
- R8: In circular mode, end_offset never exceeds the latched size_m1.
- R9: acc_valid is 1 for exactly the cycle after a step strobe and is 0 otherwise. acc_len repeats that step's incr. If start and step arrive in the same cycle, start takes effect and the step is dropped.
- R10: When neither start nor step is asserted, end_offset holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer; latches the code, offset, base and size |
| step | input | 1 | Perform one access of incr bytes at the current offset |
| buf_code | input | CODE_W | Buffer-select code |
| start_offset | input | OFS_W | Starting byte offset |
| buf_base | input | OFS_W | Circular buffer base address |
| buf_size_m1 | input | OFS_W | Circular buffer length minus one |
| incr | input | INC_W | Bytes consumed by this access |
| acc_valid | output | 1 | Access description is valid this cycle |
| acc_addr | output | OFS_W | Byte address of the access |
| acc_len | output | INC_W | Total bytes of the access |
| acc_len1 | output | INC_W | Bytes before the buffer end |
| acc_split | output | 1 | Access wraps at the buffer end |
| acc_addr2 | output | OFS_W | Address where a split access continues |
| end_offset | output | OFS_W | Current wrapped offset, used for writeback |
| circ_mode | output | 1 | Transfer uses circular addressing |

## Verification
Some properties are checked on every cycle:
- the circular offset stays inside the buffer;
- acc_valid appears only one cycle after an accepted step;
- a split happens only in circular mode and always leaves a shorter first part;
- a start loads the offset;
- the offset holds when idle.

Other properties only the bench scenarios can show:
- the exact addresses produced;
- the exact-fit wrap to zero;
- the split lengths and resume offset;
- linear rollover past 2^OFS_W;
- base and size being ignored in linear mode;
- start taking priority over a simultaneous step.

The bench compares these against a byte-by-byte model.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  typedef enum logic {
    MODE_LINEAR = 1'b0,
    MODE_CIRC   = 1'b1
  } cbg_mode_e;

  localparam logic [3:0] CODE_CIRC_SCRATCH = 4'hE;
endpackage

// File: rtl/cbg_mode_decode.sv
module cbg_mode_decode
  import cbg_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output cbg_mode_e         mode
);
  localparam logic [CODE_W-1:0] CIRC_CODE = CODE_W'(CODE_CIRC_SCRATCH);

  always_comb begin
    if (code == CIRC_CODE) mode = MODE_CIRC;
    else                   mode = MODE_LINEAR;
  end
endmodule

// File: rtl/cbg_advance.sv
module cbg_advance
  import cbg_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int INC_W = 3
) (
  input  cbg_mode_e         mode,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [OFS_W-1:0]  size_m1,
  input  logic [INC_W-1:0]  incr,
  output logic [OFS_W-1:0]  nxt_ofs,
  output logic [INC_W-1:0]  len1,
  output logic              split
);
  localparam int EXT_W = OFS_W + 1;

  logic [EXT_W-1:0] remain;
  logic [EXT_W-1:0] incr_ext;
  logic [EXT_W-1:0] over;

  always_comb begin
    incr_ext = EXT_W'(incr);
    remain   = {1'b0, size_m1} - {1'b0, ofs} + EXT_W'(1);
    over     = incr_ext - remain;
    nxt_ofs  = ofs + OFS_W'(incr);
    len1     = incr;
    split    = 1'b0;
    if (mode == MODE_CIRC) begin
      if (incr_ext == remain) begin
        nxt_ofs = '0;
      end else if (incr_ext > remain) begin
        nxt_ofs = over[OFS_W-1:0];
        len1    = remain[INC_W-1:0];
        split   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbg_addr_gen.sv
module cbg_addr_gen
  import cbg_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int OFS_W  = 16,
  parameter int INC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  input  logic [CODE_W-1:0] buf_code,
  input  logic [OFS_W-1:0]  start_offset,
  input  logic [OFS_W-1:0]  buf_base,
  input  logic [OFS_W-1:0]  buf_size_m1,
  input  logic [INC_W-1:0]  incr,
  output logic              acc_valid,
  output logic [OFS_W-1:0]  acc_addr,
  output logic [INC_W-1:0]  acc_len,
  output logic [INC_W-1:0]  acc_len1,
  output logic              acc_split,
  output logic [OFS_W-1:0]  acc_addr2,
  output logic [OFS_W-1:0]  end_offset,
  output logic              circ_mode
);
  cbg_mode_e        mode_d, mode_q;
  logic [OFS_W-1:0] base_q, size_q, ofs_q;
  logic [OFS_W-1:0] nxt_ofs;
  logic [INC_W-1:0] len1_d;
  logic             split_d;

  cbg_mode_decode #(.CODE_W(CODE_W)) u_dec (
    .code (buf_code),
    .mode (mode_d)
  );

  cbg_advance #(.OFS_W(OFS_W), .INC_W(INC_W)) u_adv (
    .mode    (mode_q),
    .ofs     (ofs_q),
    .size_m1 (size_q),
    .incr    (incr),
    .nxt_ofs (nxt_ofs),
    .len1    (len1_d),
    .split   (split_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_LINEAR;
      base_q    <= '0;
      size_q    <= '0;
      ofs_q     <= '0;
      acc_valid <= 1'b0;
      acc_addr  <= '0;
      acc_len   <= '0;
      acc_len1  <= '0;
      acc_split <= 1'b0;
      acc_addr2 <= '0;
    end else if (start) begin
      mode_q    <= mode_d;
      base_q    <= (mode_d == MODE_CIRC) ? buf_base : '0;
      size_q    <= (mode_d == MODE_CIRC) ? buf_size_m1 : '0;
      ofs_q     <= start_offset;
      acc_valid <= 1'b0;
    end else if (step) begin
      acc_valid <= 1'b1;
      acc_addr  <= (mode_q == MODE_CIRC) ? (base_q + ofs_q) : ofs_q;
      acc_len   <= incr;
      acc_len1  <= len1_d;
      acc_split <= split_d;
      acc_addr2 <= split_d ? base_q : '0;
      ofs_q     <= nxt_ofs;
    end else begin
      acc_valid <= 1'b0;
    end
  end

  assign end_offset = ofs_q;
  assign circ_mode  = (mode_q == MODE_CIRC);

  a_r8_end_in_range: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CIRC) |-> (ofs_q <= size_q));

  a_r9_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $past(step && !start));

  a_r7_split_circ_only: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_split) |-> (circ_mode && (acc_len1 < acc_len)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && !step) |=> $stable(ofs_q));

  a_r3_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (ofs_q == $past(start_offset)));
endmodule

// File: tb/cbg_addr_gen_test.sv
module cbg_addr_gen_test;
  localparam int OW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, step = 1'b0;
  logic [3:0] buf_code = '0;
  logic [OW-1:0] start_offset = '0, buf_base = '0, buf_size_m1 = '0;
  logic [IW-1:0] incr = '0;
  logic acc_valid, acc_split, circ_mode;
  logic [OW-1:0] acc_addr, acc_addr2, end_offset;
  logic [IW-1:0] acc_len, acc_len1;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [OW-1:0] addr;
    logic [IW-1:0] len;
    logic [IW-1:0] len1;
    logic          split;
    logic [OW-1:0] addr2;
    logic [OW-1:0] endo;
  } item_t;
  item_t exp_q[$];

  // bench model state
  logic          m_circ;
  logic [OW-1:0] m_base, m_size, m_ofs;

  always #2 clk = ~clk;

  cbg_addr_gen uut (
    .clk, .rst, .start, .step, .buf_code, .start_offset, .buf_base,
    .buf_size_m1, .incr, .acc_valid, .acc_addr, .acc_len, .acc_len1,
    .acc_split, .acc_addr2, .end_offset, .circ_mode
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic begin_xfer(input logic [3:0] code, input logic [OW-1:0] ofs,
                            input logic [OW-1:0] base, input logic [OW-1:0] sz);
    @(posedge clk); #1;
    start = 1; buf_code = code; start_offset = ofs; buf_base = base; buf_size_m1 = sz;
    m_circ = (code == 4'hE); m_base = base; m_size = sz; m_ofs = ofs;
    @(posedge clk); #1;
    start = 0;
  endtask

  // walk byte by byte to derive the expected access
  task automatic do_step(input logic [IW-1:0] n);
    item_t it;
    logic [OW-1:0] pos;
    it = '0;
    it.addr = m_circ ? m_base + m_ofs : m_ofs;
    it.len = n; it.len1 = n;
    pos = m_ofs;
    for (int i = 0; i < n; i++) begin
      if (m_circ && pos == m_size) begin
        pos = '0;
        if (i < n - 1 && !it.split) begin
          it.split = 1; it.len1 = IW'(i + 1); it.addr2 = m_base;
        end
      end else pos = pos + 1'b1;
    end
    m_ofs = pos;
    it.endo = pos;
    exp_q.push_back(it);
    @(posedge clk); #1;
    step = 1; incr = n;
    @(posedge clk); #1;
    step = 0;
  endtask

  // monitor / scoreboard
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (!rst && acc_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", $sformatf("unexpected acc_valid act=1 exp=0"));
        end else begin
          e = exp_q.pop_front();
          check(acc_addr == e.addr && acc_len == e.len && acc_len1 == e.len1 &&
                acc_split == e.split && acc_addr2 == e.addr2 && end_offset == e.endo,
                "R4/R5/R6/R7",
                $sformatf("act addr=%h len=%0d len1=%0d split=%0b a2=%h end=%h exp addr=%h len=%0d len1=%0d split=%0b a2=%h end=%h",
                  acc_addr, acc_len, acc_len1, acc_split, acc_addr2, end_offset,
                  e.addr, e.len, e.len1, e.split, e.addr2, e.endo));
          if (circ_mode)
            check(end_offset <= m_size, "R8", $sformatf("end act=%h max=%h", end_offset, m_size));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(!acc_valid && !acc_split && acc_addr == 0 && end_offset == 0 && !circ_mode, "R1",
          $sformatf("act v=%0b s=%0b a=%h e=%h c=%0b exp all 0",
                    acc_valid, acc_split, acc_addr, end_offset, circ_mode));

    // R5 linear scratch: base/size ignored, rollover past 2^16
    begin_xfer(4'hF, 16'hFFFA, 16'h1234, 16'h0003);
    @(negedge clk);
    check(!circ_mode, "R2", $sformatf("code F circ act=%0b exp=0", circ_mode));
    check(end_offset == 16'hFFFA, "R3", $sformatf("end act=%h exp=FFFA", end_offset));
    do_step(4); do_step(4); do_step(2);

    // R2 FIFO code is linear
    begin_xfer(4'h1, 16'h0100, 16'h4000, 16'h000F);
    @(negedge clk);
    check(!circ_mode, "R2", $sformatf("code 1 circ act=%0b exp=0", circ_mode));
    do_step(2); do_step(2);

    // circular: exact fit (R6) and split (R7)
    begin_xfer(4'hE, 16'h0008, 16'h1000, 16'h000F);
    @(negedge clk);
    check(circ_mode, "R2", $sformatf("code E circ act=%0b exp=1", circ_mode));
    check(end_offset == 16'h0008, "R3", $sformatf("end act=%h exp=0008", end_offset));
    do_step(4); do_step(4);
    @(negedge clk);
    check(end_offset == 0, "R6", $sformatf("exact wrap end act=%h exp=0", end_offset));
    do_step(3); do_step(4); do_step(4); do_step(4); do_step(4); do_step(4);

    // R7 split with 2 remaining in small buffer
    begin_xfer(4'hE, 16'h0005, 16'h2000, 16'h0006);
    do_step(4);
    @(negedge clk);
    check(end_offset == 16'h0002, "R7", $sformatf("resume act=%h exp=0002", end_offset));
    do_step(1); do_step(4);

    // R10 idle hold
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(end_offset == m_ofs, "R10", $sformatf("idle end act=%h exp=%h", end_offset, m_ofs));

    // R9 start and step together: start wins
    @(posedge clk); #1;
    start = 1; step = 1; incr = 3; buf_code = 4'hF; start_offset = 16'h0040;
    m_circ = 0; m_ofs = 16'h0040;
    @(posedge clk); #1;
    start = 0; step = 0;
    @(negedge clk);
    check(!acc_valid && end_offset == 16'h0040, "R9",
          $sformatf("start+step act v=%0b end=%h exp v=0 end=0040", acc_valid, end_offset));
    do_step(3);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R9", $sformatf("pending act=%0d exp=0", exp_q.size()));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule